// File: doc/BRIEF.md
# Step-Accumulating Counter with Capture

This cell is a pin-side event counter built as an accumulator. On every clock where the enable strobe is high, the count moves up or down by either one or a programmable step. Which way it moves is set by a direction strobe, so a quadrature decoder can steer it. Whether the step is one or the programmed value is set by a step-mode strobe.

A load strobe copies a preset value into the count, which suits period reload. A capture strobe freezes the current count into a separate snapshot register. When saturation is selected, the count clamps at its end value instead of rolling over. A one-clock terminal flag marks a rollover or the arrival at the clamp.

Software reaches the 32-bit state through a small register port:

- The count can be read and written.
- The snapshot can only be read.
- The preset and step registers can only be written.

A synchronous clear strobe zeroes the count.

Top module: `ctr_cap_cell`

## Requirements
- R1: While rst_ni is low, the count, snapshot and preset are 0, the step register is 1 and tc_o is 0.
- R2: A high clr_i zeroes the count and drops tc_o at the next edge. This takes priority over load, register writes and counting.
- R3: A high load_i (without clr_i) copies the preset into the count at the next edge. This takes priority over a count-register write and counting.
- R4: With step_mode_i low and en_i high, the count moves by 1: up when dir_i is 1, down when dir_i is 0. With en_i low and no clear, load or write, the count holds and tc_o stays 0.
- R5: With step_mode_i high, each enabled clock adds or subtracts the step register value. The step register is 1 after reset.
- R6: With sat_i low, counting wraps modulo 2^32. tc_o is high for exactly the clock after the edge where an up-count carried past all ones or a down-count borrowed past zero.
- R7: With sat_i high, counting clamps at all ones (up) or zero (down). tc_o is high for the clock after the edge that reached the clamp value. Further enabled clocks at the clamp keep the count there with tc_o low.
- R8: A high capt_i stores into the snapshot the count as it was before that edge's update.
- R9: The register map is as follows. Address 0 is the count, readable and writable. Address 1 is the snapshot, read-only; writes to it are ignored. Address 2 is the preset and address 3 is the step; both are write-only and read as 0. reg_rdata_o is combinational from reg_addr_i.
- R10: A write to address 0 sets the count at the next edge and discards any counting update on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous count clear strobe |
| dir_i | input | 1 | 1 = count up, 0 = count down |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Load preset into count |
| capt_i | input | 1 | Capture count into snapshot |
| sat_i | input | 1 | 1 = saturate, 0 = wrap |
| step_mode_i | input | 1 | 1 = use step register, 0 = step of 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| count_o | output | 32 | Current count |
| tc_o | output | 1 | Terminal-count pulse |

## Verification
Several behaviours are checked by the embedded assertions on every cycle:

- clear and load results;
- holding while disabled;
- the value written to the count and to the step register;
- the snapshot taking the pre-update count;
- saturating counts never moving against their direction.

Only the bench scenarios show the rest: the exact rollover values and terminal pulses at both ends, the clamp arrival followed by a silent hold, and the priority outcomes when strobes coincide. The bench scenarios also cover the write-only and read-only behaviour of the register map.

// File: rtl/ctr_cap_pkg.sv
package ctr_cap_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_SNAP   = 2'd1,
    REG_PRESET = 2'd2,
    REG_STEP   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ctr_next_calc.sv
module ctr_next_calc #(
  parameter int W = 32
) (
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] step_i,
  input  logic         up_i,
  input  logic         sat_i,
  output logic [W-1:0] next_o,
  output logic         term_o
);
  localparam logic [W-1:0] HI = '1;
  localparam logic [W-1:0] LO = '0;

  logic [W:0]   ext;
  logic         over;
  logic [W-1:0] lim;

  always_comb begin
    if (up_i) begin
      ext = {1'b0, count_i} + {1'b0, step_i};
      lim = HI;
    end else begin
      ext = {1'b0, count_i} - {1'b0, step_i};
      lim = LO;
    end
    over = ext[W];
    if (sat_i) begin
      next_o = over ? lim : ext[W-1:0];
      // pulse only on arrival, not while parked at the clamp
      term_o = (count_i != lim) && (over || ext[W-1:0] == lim);
    end else begin
      next_o = ext[W-1:0];
      term_o = over;
    end
  end
endmodule

// File: rtl/ctr_cfg_regs.sv
module ctr_cfg_regs
  import ctr_cap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] preset_o,
  output logic [W-1:0] step_o
);
  localparam logic [W-1:0] STEP_RST = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_o <= '0;
      step_o   <= STEP_RST;
    end else if (we_i) begin
      if (addr_i == REG_PRESET) preset_o <= wdata_i;
      if (addr_i == REG_STEP)   step_o   <= wdata_i;
    end
  end

  assert_step_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STEP) |=> step_o == $past(wdata_i));
endmodule

// File: rtl/ctr_snap_reg.sv
module ctr_snap_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capt_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_o <= '0;
    else if (capt_i) snap_o <= count_i;
  end

  assert_snap_pre_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt_i |=> snap_o == $past(count_i));
endmodule

// File: rtl/ctr_cap_cell.sv
module ctr_cap_cell
  import ctr_cap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         dir_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic         capt_i,
  input  logic         sat_i,
  input  logic         step_mode_i,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count_q, preset, step_reg, snap, step_eff, next;
  logic         tc_q, term, count_wr;

  assign count_wr = reg_we_i && (reg_addr_i == REG_COUNT);
  assign step_eff = step_mode_i ? step_reg : ONE;

  ctr_cfg_regs #(.W(W)) u_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .preset_o(preset), .step_o(step_reg)
  );

  ctr_snap_reg #(.W(W)) u_snap (
    .clk_i, .rst_ni, .capt_i, .count_i(count_q), .snap_o(snap)
  );

  ctr_next_calc #(.W(W)) u_next (
    .count_i(count_q), .step_i(step_eff), .up_i(dir_i), .sat_i,
    .next_o(next), .term_o(term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      tc_q    <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      tc_q    <= 1'b0;
    end else if (load_i) begin
      count_q <= preset;
      tc_q    <= 1'b0;
    end else if (count_wr) begin
      count_q <= reg_wdata_i;  // same-edge count update dropped
      tc_q    <= 1'b0;
    end else if (en_i) begin
      count_q <= next;
      tc_q    <= term;
    end else begin
      tc_q    <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr_i))
      REG_COUNT: reg_rdata_o = count_q;
      REG_SNAP:  reg_rdata_o = snap;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign count_o = count_q;
  assign tc_o    = tc_q;

  assert_clr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0) && !tc_q);
  assert_load_preset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> count_q == $past(preset));
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !count_wr && !en_i) |=> $stable(count_q) && !tc_q);
  assert_sat_up_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_i && dir_i && !clr_i && !load_i && !count_wr)
      |=> count_q >= $past(count_q));
  assert_sat_dn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_i && !dir_i && !clr_i && !load_i && !count_wr)
      |=> count_q <= $past(count_q));
  assert_wr_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_wr && !clr_i && !load_i) |=> count_q == $past(reg_wdata_i));
endmodule

// File: tb/tb_ctr_cap_cell.sv
module tb_ctr_cap_cell;
  timeunit 1ns; timeprecision 1ps;

  logic        clk_i = 0, rst_ni = 0;
  logic        clr_i = 0, dir_i = 0, en_i = 0, load_i = 0, capt_i = 0;
  logic        sat_i = 0, step_mode_i = 0, reg_we_i = 0;
  logic [1:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o, count_o;
  logic        tc_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  ctr_cap_cell dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] exp);
    reg_addr_i = a; #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, 0);
    chk("R1 tc", 32'(tc_o), 0);
    rd("R1 snap", 2'd1, 0);
    rd("R1 preset reads 0", 2'd2, 0);
  endtask

  task automatic t_count();
    en_i = 1; dir_i = 1; cyc(); cyc(); cyc();
    chk("R4 up by one", count_o, 3);
    dir_i = 0; cyc();
    chk("R4 down by one", count_o, 2);
    en_i = 0; cyc();
    chk("R4 hold", count_o, 2);
    chk("R4 tc low", 32'(tc_o), 0);
  endtask

  task automatic t_step();
    step_mode_i = 1; en_i = 1; dir_i = 1; cyc();
    chk("R5 default step", count_o, 3);
    en_i = 0; wr(2'd3, 5);
    en_i = 1; cyc(); cyc();
    chk("R5 step up", count_o, 13);
    dir_i = 0; cyc();
    chk("R5 step down", count_o, 8);
    en_i = 0; step_mode_i = 0;
    rd("R9 step reads 0", 2'd3, 0);
  endtask

  task automatic t_wrap();
    sat_i = 0; wr(2'd0, 32'hFFFF_FFFE);
    chk("R10 write", count_o, 32'hFFFF_FFFE);
    en_i = 1; dir_i = 1; cyc();
    chk("R6 near top", count_o, 32'hFFFF_FFFF);
    chk("R6 no tc", 32'(tc_o), 0);
    cyc();
    chk("R6 wrap up", count_o, 0);
    chk("R6 tc up", 32'(tc_o), 1);
    cyc();
    chk("R6 tc one clock", 32'(tc_o), 0);
    dir_i = 0; cyc(); cyc();
    chk("R6 wrap down", count_o, 32'hFFFF_FFFF);
    chk("R6 tc down", 32'(tc_o), 1);
    en_i = 0; cyc();
    chk("R6 tc drop", 32'(tc_o), 0);
  endtask

  task automatic t_sat();
    sat_i = 1; step_mode_i = 1;
    wr(2'd3, 2); wr(2'd0, 32'hFFFF_FFFD);
    en_i = 1; dir_i = 1; cyc();
    chk("R7 reach top", count_o, 32'hFFFF_FFFF);
    chk("R7 tc top", 32'(tc_o), 1);
    cyc();
    chk("R7 clamp top", count_o, 32'hFFFF_FFFF);
    chk("R7 tc quiet top", 32'(tc_o), 0);
    en_i = 0; wr(2'd3, 5); wr(2'd0, 3);
    dir_i = 0; en_i = 1; cyc();
    chk("R7 clamp zero", count_o, 0);
    chk("R7 tc zero", 32'(tc_o), 1);
    cyc();
    chk("R7 hold zero", count_o, 0);
    chk("R7 tc quiet zero", 32'(tc_o), 0);
    en_i = 0; sat_i = 0; step_mode_i = 0;
  endtask

  task automatic t_capture();
    wr(2'd0, 100);
    en_i = 1; dir_i = 1; capt_i = 1; cyc();
    en_i = 0; capt_i = 0;
    chk("R8 count moved", count_o, 101);
    rd("R8 snap pre-update", 2'd1, 100);
    wr(2'd1, 55);
    rd("R9 snap read-only", 2'd1, 100);
    wr(2'd2, 32'h1234);
    rd("R9 preset reads 0", 2'd2, 0);
    rd("R9 count readable", 2'd0, 101);
  endtask

  task automatic t_prio();
    en_i = 1; dir_i = 1; load_i = 1; cyc();
    chk("R3 load beats count", count_o, 32'h1234);
    clr_i = 1; cyc();
    chk("R2 clr beats load", count_o, 0);
    clr_i = 0; load_i = 0;
    wr(2'd0, 32'h50);
    chk("R10 write drops count", count_o, 32'h50);
    cyc();
    chk("R10 counting resumes", count_o, 32'h51);
    load_i = 1; wr(2'd0, 32'h77);
    chk("R3 load beats write", count_o, 32'h1234);
    load_i = 0; en_i = 0;
  endtask

  initial begin
    #(20ns * 100000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_ni = 1;
    cyc();
    t_count();
    t_step();
    t_wrap();
    t_sat();
    t_capture();
    t_prio();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule